// File: doc/BRIEF.md
# Paged Register Access Port over I2C

This block is a two-wire serial slave that lets a host reach the register space of an LED matrix controller. The space is split into five pages. Three global registers sit at the top of every page. One holds the device identity. One selects the page. The third is a one-shot key that must be written before the page select accepts a new value. Every other location is forwarded to external page storage through a simple synchronous strobe interface. The block places the current page number and the register pointer on that interface.

A host writes a register pointer, then any number of data bytes, and the pointer steps by one after each byte. To read, the host writes the pointer, issues a repeated START and re-addresses the device for reading. Bytes then stream out from the pointer onward until the host answers with a NACK. A reset code written to a reserved location of page 4 returns every register to its default. It also tells the storage to clear itself.

The storage side has no back-pressure. A write or read strobe lasts one cycle and is always taken in that cycle. Read data must be valid on the cycle that follows the read strobe. The serial side is sampled after a two-flop synchroniser. Each SCL phase must therefore last at least four system clocks.

Top module: `pgreg_i2c_top`

## Requirements
- R1: The device acknowledges only the 7-bit address {01100, strap_i[1:0]}. Any other address gets no acknowledge, and no strobe appears on the storage interface until the next START.
- R2: Bytes are shifted MSB first, and the device pulls SDA low for the acknowledge bit after each address or data byte it accepts. It changes sda_oe_o only while SCL is low.
- R3: In a write, the first byte after the address loads the register pointer. Each following data byte goes to the pointer, and the pointer then advances by one.
- R4: After a repeated START with R/W = 1, the device sends the byte at the pointer and advances the pointer. It sends the next byte each time the host acknowledges. For storage locations it issues a one-cycle mem_rd_o with the current page and address.
- R5: A NACK from the host ends the read. SDA stays released (reads as 1) and no further read strobe is issued until the next START.
- R6: After reset the page is 0 and the page select (0xFD) is locked. Writes to it then leave the page unchanged, yet the byte is still acknowledged.
- R7: Writing 0xC5 to the key register (0xFE) allows exactly one write to 0xFD. Any write to 0xFD clears the key to 0x00. A key written with any other value reads back as written but does not unlock.
- R8: A page-select value above 4 is ignored, and the page stays as it was. Any page on the storage interface during a strobe is in the range 0..4.
- R9: Reading 0xFC returns {01100, strap_i, 0}, the device's own 8-bit write address. Writes to 0xFC change nothing.
- R10: Reading 0xFD returns 0x00 and reading 0xFE returns the key byte. Neither of them, nor 0xFC, is ever forwarded to storage.
- R11: Writing 0xAE to location 0x3F while on page 4 pulses mem_clear_o for one cycle and returns the page and key to 0. Any other value there has no effect. Neither kind of write reaches storage.
- R12: mem_wr_o and mem_rd_o are single-cycle strobes and never coincide. After reset both are low and SDA is released.
- R13: A START at any point, including in the middle of a byte, restarts address reception. After a STOP, clock pulses without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Low bits of the slave address |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| mem_wr_o | output | 1 | One-cycle storage write strobe |
| mem_rd_o | output | 1 | One-cycle storage read strobe |
| mem_page_o | output | 3 | Current page (0..4) |
| mem_addr_o | output | 8 | Register pointer |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| mem_clear_o | output | 1 | One-cycle request to clear all page storage |

## Verification
Some properties are checked on every cycle. SDA only moves while SCL is low. The storage strobes are single pulses that never overlap. A strobe never carries a page above 4. The global registers never leak into a storage read. A clear is followed by page 0. Other behaviour can only be shown by the bench's transaction scenarios. These cover address matching across the full 7-bit space and each strap value, the pointer stepping over multi-byte writes and reads, and the one-shot key consumed across a sweep of every page value. They also cover the exact effect of the reset code, and recovery from an aborted byte.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam logic [7:0] REG_ID       = 8'hFC;
  localparam logic [7:0] REG_PAGESEL  = 8'hFD;
  localparam logic [7:0] REG_KEY      = 8'hFE;
  localparam logic [7:0] KEY_OPEN     = 8'hC5;
  localparam logic [7:0] SRST_LOC     = 8'h3F;
  localparam logic [7:0] SRST_CODE    = 8'hAE;
  localparam int         SRST_PAGE    = 4;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_WBYTE,
    LK_WACK,
    LK_RBYTE,
    LK_RACK
  } link_state_t;
endpackage

// File: rtl/pgreg_sync.sv
module pgreg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgreg_cond.sv
module pgreg_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] synced;
  logic scl_d, sda_d, scl_s;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    pgreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (synced[g])
    );
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/pgreg_link.sv
module pgreg_link
  import pgreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  input  logic       rd_valid,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_ld,
  output logic       wr_stb,
  output logic       rd_req,
  output logic [7:0] rx_byte
);
  localparam logic [3:0] BITS = 4'd8;

  link_state_t st;
  logic [3:0]  cnt;
  logic [7:0]  rx_sr;
  logic [7:0]  tx_sr;
  logic        rw;
  logic        first;
  logic        acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= LK_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      acked   <= 1'b0;
      sda_oe  <= 1'b0;
      ptr_ld  <= 1'b0;
      wr_stb  <= 1'b0;
      rd_req  <= 1'b0;
      rx_byte <= '0;
    end else begin
      ptr_ld <= 1'b0;
      wr_stb <= 1'b0;
      rd_req <= 1'b0;
      if (rd_valid) tx_sr <= rd_data;
      if (start_det) begin
        st     <= LK_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_WBYTE: begin
            if (scl_rise && cnt < BITS) begin
              rx_sr <= {rx_sr[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              if (st == LK_ADDR) begin
                if (rx_sr[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= rx_sr[0];
                  st     <= LK_AACK;
                end else begin
                  st <= LK_IDLE;
                end
              end else begin
                sda_oe  <= 1'b1;
                rx_byte <= rx_sr;
                st      <= LK_WACK;
                if (first) ptr_ld <= 1'b1;
                else       wr_stb <= 1'b1;
              end
            end
          end
          LK_AACK: begin
            if (scl_rise && rw) rd_req <= 1'b1;
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st     <= LK_RBYTE;
                sda_oe <= ~tx_sr[7];
              end else begin
                st     <= LK_WBYTE;
                first  <= 1'b1;
                sda_oe <= 1'b0;
              end
            end
          end
          LK_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              first  <= 1'b0;
              st     <= LK_WBYTE;
            end
          end
          LK_RBYTE: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= LK_RACK;
              end else begin
                cnt    <= cnt + 4'd1;
                tx_sr  <= {tx_sr[6:0], 1'b0};
                sda_oe <= ~tx_sr[6];
              end
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              acked <= ~sda_s;
              if (!sda_s) rd_req <= 1'b1;
            end
            if (scl_fall) begin
              if (acked) begin
                st     <= LK_RBYTE;
                cnt    <= '0;
                sda_oe <= ~tx_sr[7];
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgreg_regctl.sv
module pgreg_regctl
  import pgreg_pkg::*;
#(
  parameter int N_PAGES = 5,
  localparam int PW = $clog2(N_PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    id_byte,
  input  logic          ptr_ld,
  input  logic          wr_stb,
  input  logic          rd_req,
  input  logic [7:0]    byte_in,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [PW-1:0] mem_page,
  output logic [7:0]    mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_clear
);
  logic [7:0]    ptr_q;
  logic [PW-1:0] page_q;
  logic [7:0]    key_q;
  logic          pend_q;
  logic          local_q;
  logic [7:0]    lval_q;

  logic hit_id, hit_pg, hit_key, hit_rst, hit_glob, srst_go;

  assign hit_id   = (ptr_q == REG_ID);
  assign hit_pg   = (ptr_q == REG_PAGESEL);
  assign hit_key  = (ptr_q == REG_KEY);
  assign hit_rst  = (page_q == PW'(SRST_PAGE)) && (ptr_q == SRST_LOC);
  assign hit_glob = hit_id | hit_pg | hit_key | hit_rst;
  assign srst_go  = wr_stb & hit_rst & (byte_in == SRST_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      page_q  <= '0;
      key_q   <= '0;
      pend_q  <= 1'b0;
      local_q <= 1'b0;
      lval_q  <= '0;
    end else begin
      pend_q <= rd_req;
      if (ptr_ld) begin
        ptr_q <= byte_in;
      end else if (wr_stb) begin
        ptr_q <= ptr_q + 8'd1;
        if (hit_pg) begin
          key_q <= '0;
          if (key_q == KEY_OPEN && byte_in < 8'(N_PAGES))
            page_q <= byte_in[PW-1:0];
        end else if (hit_key) begin
          key_q <= byte_in;
        end else if (srst_go) begin
          page_q <= '0;
          key_q  <= '0;
        end
      end else if (rd_req) begin
        ptr_q   <= ptr_q + 8'd1;
        local_q <= hit_glob;
        if (hit_id)       lval_q <= id_byte;
        else if (hit_key) lval_q <= key_q;
        else              lval_q <= '0;
      end
    end
  end

  assign rd_valid  = pend_q;
  assign rd_data   = local_q ? lval_q : mem_rdata;
  assign mem_wr    = wr_stb & ~hit_glob;
  assign mem_rd    = rd_req & ~hit_glob;
  assign mem_page  = page_q;
  assign mem_addr  = ptr_q;
  assign mem_wdata = byte_in;
  assign mem_clear = srst_go;
endmodule

// File: rtl/pgreg_i2c_top.sv
module pgreg_i2c_top #(
  parameter int         N_PAGES     = 5,
  parameter int         STRAP_W     = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h30,
  parameter int         SYNC_STAGES = 2,
  localparam int        PW          = $clog2(N_PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic               mem_wr_o,
  output logic               mem_rd_o,
  output logic [PW-1:0]      mem_page_o,
  output logic [7:0]         mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               mem_clear_o
);
  logic       scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic       ptr_ld, wr_stb, rd_req, rd_valid;
  logic [7:0] rx_byte, rd_data;
  logic [6:0] dev_addr;

  assign dev_addr = {ADDR_BASE[6:STRAP_W], strap_i};

  pgreg_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  pgreg_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .dev_addr (dev_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe_o),
    .ptr_ld   (ptr_ld),
    .wr_stb   (wr_stb),
    .rd_req   (rd_req),
    .rx_byte  (rx_byte)
  );

  pgreg_regctl #(.N_PAGES(N_PAGES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_byte  ({dev_addr, 1'b0}),
    .ptr_ld   (ptr_ld),
    .wr_stb   (wr_stb),
    .rd_req   (rd_req),
    .byte_in  (rx_byte),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .mem_wr   (mem_wr_o),
    .mem_rd   (mem_rd_o),
    .mem_page (mem_page_o),
    .mem_addr (mem_addr_o),
    .mem_wdata(mem_wdata_o),
    .mem_rdata(mem_rdata_i),
    .mem_clear(mem_clear_o)
  );
endmodule

// File: rtl/pgreg_checker.sv
module pgreg_checker #(
  parameter int N_PAGES = 5,
  localparam int PW = $clog2(N_PAGES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          mem_wr_o,
  input logic          mem_rd_o,
  input logic [PW-1:0] mem_page_o,
  input logic [7:0]    mem_addr_o,
  input logic          mem_clear_o
);
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o));

  assert_wr_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> !mem_wr_o);

  assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  assert_page_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o || mem_rd_o) |-> (int'(mem_page_o) < N_PAGES));

  assert_clear_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear_o |=> (mem_page_o == '0));

  assert_clear_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear_o |=> !mem_clear_o);

  assert_globals_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_addr_o < 8'hFC || mem_addr_o == 8'hFF));
endmodule

bind pgreg_i2c_top pgreg_checker #(.N_PAGES(N_PAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .mem_wr_o   (mem_wr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_page_o (mem_page_o),
  .mem_addr_o (mem_addr_o),
  .mem_clear_o(mem_clear_o)
);

// File: tb/tb_pgreg_i2c_top.sv
module tb_pgreg_i2c_top;
  localparam int NP = 5;
  localparam int Q  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe, mem_wr, mem_rd, mem_clear;
  logic [2:0] mem_page;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire        sda_line = m_sda & ~sda_oe;

  logic [7:0] mem [0:NP-1][0:255];
  int wr_count = 0, rd_count = 0, clr_count = 0;
  int last_page = -1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pgreg_i2c_top dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .mem_page_o(mem_page),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_clear_o(mem_clear)
  );

  always @(posedge clk) begin
    if (!rst_n || mem_clear) begin
      for (int p = 0; p < NP; p++)
        for (int a = 0; a < 256; a++) mem[p][a] <= 8'h00;
      if (mem_clear) clr_count <= clr_count + 1;
    end else begin
      if (mem_wr) begin
        mem[mem_page][mem_addr] <= mem_wdata;
        wr_count  <= wr_count + 1;
        last_page <= int'(mem_page);
      end
      if (mem_rd) begin
        mem_rdata <= mem[mem_page][mem_addr];
        rd_count  <= rd_count + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(nack);
  endtask

  function automatic logic [7:0] devw();
    return {5'b01100, strap, 1'b0};
  endfunction

  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] d, input string tag);
    logic a;
    i2c_start();
    wbyte(devw(), a); chk({tag, " R2 addr ack"}, a, 1);
    wbyte(ptr, a);    chk({tag, " R2 ptr ack"}, a, 1);
    wbyte(d, a);      chk({tag, " R2 data ack"}, a, 1);
    i2c_stop();
  endtask

  task automatic reg_read(input logic [7:0] ptr, output logic [7:0] d);
    logic a;
    i2c_start();
    wbyte(devw(), a); chk("R2 read addr ack", a, 1);
    wbyte(ptr, a);    chk("R2 read ptr ack", a, 1);
    i2c_start();
    wbyte(devw() | 8'h01, a); chk("R4 read dev ack", a, 1);
    rbyte(1'b1, d);
    i2c_stop();
  endtask

  initial begin
    int wc;
    int rc;
    int cur;
    int expp;
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R12 reset sda released", sda_oe, 0);
    chk("R12 reset no write", mem_wr, 0);
    chk("R12 reset no clear", mem_clear, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: full sweep of the 7-bit address space
    for (int ad = 0; ad < 128; ad++) begin
      i2c_start();
      wbyte({ad[6:0], 1'b0}, a);
      i2c_stop();
      chk($sformatf("R1 ack for addr %0h", ad), a, (ad == 8'h30) ? 1 : 0);
    end
    chk("R1 no strobes during sweep", wr_count + rd_count, 0);

    // R3: multi-byte write with pointer stepping
    i2c_start();
    wbyte(devw(), a); chk("R2 burst addr ack", a, 1);
    wbyte(8'h20, a);  chk("R2 burst ptr ack", a, 1);
    for (int i = 0; i < 5; i++) begin
      wbyte(8'(8'h11 * i + 3), a);
      chk("R2 burst data ack", a, 1);
    end
    i2c_stop();
    chk("R3 write count", wr_count, 5);
    for (int i = 0; i < 5; i++)
      chk($sformatf("R3 stored byte %0d", i), mem[0][8'h20 + i], (8'h11 * i + 3) & 8'hFF);

    // R4, R5: repeated-start burst read, NACK ends it
    i2c_start();
    wbyte(devw(), a);
    wbyte(8'h20, a);
    i2c_start();
    wbyte(devw() | 8'h01, a); chk("R4 read dev ack", a, 1);
    for (int i = 0; i < 5; i++) begin
      rbyte((i == 4) ? 1'b1 : 1'b0, d);
      chk($sformatf("R4 read byte %0d", i), d, (8'h11 * i + 3) & 8'hFF);
    end
    chk("R4 read strobes", rd_count, 5);
    rc = rd_count;
    rbyte(1'b1, d);
    chk("R5 released after nack", d, 8'hFF);
    chk("R5 no strobe after nack", rd_count, rc);
    i2c_stop();

    // R6: locked page select
    reg_write(8'hFD, 8'h02, "R6");
    reg_write(8'h10, 8'hA5, "R6");
    chk("R6 page stays 0", last_page, 0);
    reg_read(8'hFE, d); chk("R10 key reads 0", d, 0);
    reg_read(8'hFD, d); chk("R10 page select reads 0", d, 0);

    // R7, R8: sweep every page value through the key
    cur = 0;
    for (int v = 0; v < 8; v++) begin
      reg_write(8'hFE, 8'hC5, "R7");
      reg_read(8'hFE, d); chk("R7 key reads back C5", d, 8'hC5);
      reg_write(8'hFD, 8'(v), "R7");
      reg_read(8'hFE, d); chk("R7 key cleared after use", d, 0);
      if (v < NP) cur = v;
      reg_write(8'h40, 8'(v ^ 8'h5A), "R8");
      chk($sformatf("R8 page after value %0d", v), last_page, cur);
    end
    reg_write(8'hFE, 8'h33, "R7");
    reg_read(8'hFE, d); chk("R7 other key reads back", d, 8'h33);
    reg_write(8'hFD, 8'h01, "R7");
    reg_write(8'h41, 8'h01, "R7");
    chk("R7 one shot no second change", last_page, cur);

    // R11: soft reset location on page 4
    wc = wr_count;
    reg_write(8'h3F, 8'h12, "R11");
    chk("R11 other code no clear", clr_count, 0);
    chk("R11 other code not stored", wr_count, wc);
    reg_write(8'h42, 8'h09, "R11");
    chk("R11 page kept after other code", last_page, 4);
    wc = wr_count;
    reg_write(8'h3F, 8'hAE, "R11");
    chk("R11 clear pulse", clr_count, 1);
    chk("R11 code not stored", wr_count, wc);
    reg_write(8'h05, 8'h77, "R11");
    chk("R11 page back to 0", last_page, 0);
    reg_read(8'h20, d); chk("R11 storage cleared", d, 0);

    // R9, R1: identity for every strap value
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      wc = wr_count;
      reg_write(8'hFC, 8'h99, "R9");
      chk("R9 id write not stored", wr_count, wc);
      reg_read(8'hFC, d);
      chk($sformatf("R9 id strap %0d", s), d, (8'h30 | s) << 1);
      if (s != 0) begin
        i2c_start(); wbyte(8'h60, a); i2c_stop();
        chk("R1 base address ignored", a, 0);
      end
    end
    strap = 2'b00;

    // R13: START in the middle of a byte, clocks after STOP
    i2c_start();
    wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
    i2c_start();
    wbyte(devw(), a); chk("R13 restart addr ack", a, 1);
    wbyte(8'h30, a);
    wbyte(8'h42, a);
    i2c_stop();
    chk("R13 write after abort", mem[0][8'h30], 8'h42);
    i2c_start(); wbyte(devw(), a); i2c_stop();
    m_scl = 1'b0; qw();
    wbyte(devw(), a);
    chk("R13 no ack without start", a, 0);
    i2c_stop();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule